// File: doc/BRIEF.md
# Time-Multiplexed Queue Oscillator

This block keeps a bank of oscillator slots in one memory and visits them in a fixed round. Each slot holds an opcode, a compact floating-point increment and a 27-bit current value. A read pointer steps through the slots one per clock with no branching, so each slot is updated exactly once per pass. The pass period is the block's single time base. Each visit reads the slot and turns the increment into a fixed-point magnitude. That magnitude is then applied to the current value in a way set by the slot's data type. Three clocks after the read, only the current value goes back into the same slot.

Sine-argument slots wrap modulo the full 27-bit range and publish a quadrant and a table index for a downstream lookup. Ramp slots saturate on positive overflow, and exponential (log-domain) slots saturate on negative underflow; in both cases the write-back is withheld. A host write port loads whole slots. The per-visit result stream feeds an arithmetic unit that sits further down the chain.

Top module: `wq_osc`

## Requirements
- R1: `rd_slot` advances by one every clock and wraps from DEPTH-1 to 0. It holds at 0 during reset.
- R2: When `out_valid` is high, `out_slot` equals `rd_slot` minus 3 modulo DEPTH. After reset is released, the first valid result, for slot 0, appears after the third rising edge.
- R3: The 18-bit increment is a shift count in bits 17..14 and a mantissa in bits 13..0. The mantissa, with a leading bit in front of it, is placed at bits 26..12 and shifted right by the count, and the bits shifted out are dropped. The leading bit is 1 for sine types and 0 for every other type.
- R4: The update never changes the opcode or the increment. `out_op` reports the stored opcode on every visit.
- R5: Types 0 (modulated sine) and 1 (plain sine) add the magnitude modulo 2^27. `out_quad` is bits 26..25 of the result and `out_index` is bits 24..15.
- R6: Type 2 (exponential) subtracts the magnitude from the value taken as signed. If the result would fall below -2^26, nothing is written and the value stays as it was.
- R7: Type 3 (ramp) adds the magnitude to the value taken as signed. If the result would exceed 2^26-1, nothing is written and the value stays as it was.
- R8: Types 4 to 7 (special, extended, reserved) leave the current value unchanged.
- R9: A host write (`host_we`) loads opcode, increment and value of one slot at the next edge. If it hits the slot being written back in that same cycle, the host data wins.
- R10: During reset `out_valid` is low.

The type is opcode bits 8..6. `out_value` is the value the slot holds after the visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Minor-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host slot write enable |
| host_addr | input | 6 | Host slot address |
| host_op | input | 9 | Opcode to load |
| host_inc | input | 18 | Increment to load |
| host_cur | input | 27 | Current value to load |
| rd_slot | output | 6 | Slot being read this cycle |
| out_valid | output | 1 | A visit result is present |
| out_slot | output | 6 | Slot of the result (write-back slot) |
| out_op | output | 9 | Opcode of that slot |
| out_value | output | 27 | Value the slot holds after the visit |
| out_quad | output | 2 | Sine quadrant of out_value |
| out_index | output | 10 | Sine table index of out_value |

## Verification
The table mixes all eight data types across the 64 slots, with shift counts from 0 to 15 and spread mantissas. Every visit is compared with a model that computes the magnitude by multiplication and division rather than by shifting, so the mix of types tells the leading-bit and direction rules apart. Hand-computed slots cover the 0 and 15 shift extremes: a half-cycle sine step, a sine wrap past 2^27 with truncation, and an exact ramp step. A ramp slot and an exponential slot are placed two steps from their limits, so that saturation and holding can be told apart from wrapping. A host write to the slot in write-back shows whether the host data or the computed value is kept.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int OP_W    = 9;
  localparam int TYPE_W  = 3;
  localparam int SHIFT_W = 4;
  localparam int MANT_W  = 14;
  localparam int INC_W   = SHIFT_W + MANT_W;
  localparam int CUR_W   = 27;
  localparam int QUAD_W  = 2;
  localparam int IDX_W   = 10;
  localparam int PAD_W   = CUR_W - 1 - MANT_W;

  typedef enum logic [TYPE_W-1:0] {
    DT_SINE_MOD = 3'd0,
    DT_SINE     = 3'd1,
    DT_EXP      = 3'd2,
    DT_RAMP     = 3'd3,
    DT_SPECIAL  = 3'd4,
    DT_EXTENDED = 3'd5,
    DT_RSVD6    = 3'd6,
    DT_RSVD7    = 3'd7
  } dtype_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [INC_W-1:0] inc;
    logic [CUR_W-1:0] cur;
  } slot_t;

  typedef struct packed {
    logic             wr;
    logic [CUR_W-1:0] val;
  } step_t;

  function automatic dtype_e op_type(input logic [OP_W-1:0] op);
    return dtype_e'(op[OP_W-1 -: TYPE_W]);
  endfunction

  function automatic logic is_sine(input dtype_e t);
    return (t == DT_SINE_MOD) || (t == DT_SINE);
  endfunction

  // Mantissa plus leading bit placed under the top of the value word, then
  // right-shifted by the count; bits leaving the bottom are truncated.
  function automatic logic [CUR_W-1:0] align_inc(input logic [INC_W-1:0] inc,
                                                 input logic lead);
    logic [CUR_W-1:0] placed;
    placed = {lead, inc[MANT_W-1:0], {PAD_W{1'b0}}};
    return placed >> inc[INC_W-1 -: SHIFT_W];
  endfunction

  function automatic step_t step_value(input dtype_e t,
                                       input logic [CUR_W-1:0] cur,
                                       input logic [CUR_W-1:0] mag);
    logic [CUR_W:0] wide;
    step_t r;
    wide  = '0;
    r.wr  = 1'b0;
    r.val = cur;
    case (t)
      DT_SINE_MOD, DT_SINE: begin
        r.wr  = 1'b1;
        r.val = cur + mag;
      end
      DT_RAMP: begin
        wide = {cur[CUR_W-1], cur} + {1'b0, mag};
        if (wide[CUR_W] == wide[CUR_W-1]) begin
          r.wr  = 1'b1;
          r.val = wide[CUR_W-1:0];
        end
      end
      DT_EXP: begin
        wide = {cur[CUR_W-1], cur} - {1'b0, mag};
        if (wide[CUR_W] == wide[CUR_W-1]) begin
          r.wr  = 1'b1;
          r.val = wide[CUR_W-1:0];
        end
      end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/wq_seq.sv
module wq_seq #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] rd_slot
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_slot <= '0;
    else if (rd_slot == LAST)  rd_slot <= '0;
    else                       rd_slot <= rd_slot + 1'b1;
  end
endmodule

// File: rtl/wq_align_stage.sv
module wq_align_stage import wq_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  slot_t             in_slot,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [OP_W-1:0]   out_op,
  output logic [CUR_W-1:0]  out_cur,
  output logic [CUR_W-1:0]  out_mag
);
  logic             lead;
  logic [CUR_W-1:0] mag_c;

  always_comb begin
    lead  = is_sine(op_type(in_slot.op));
    mag_c = align_inc(in_slot.inc, lead);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_op    <= '0;
      out_cur   <= '0;
      out_mag   <= '0;
    end else begin
      out_valid <= in_valid;
      out_addr  <= in_addr;
      out_op    <= in_slot.op;
      out_cur   <= in_slot.cur;
      out_mag   <= mag_c;
    end
  end
endmodule

// File: rtl/wq_step_stage.sv
module wq_step_stage import wq_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [OP_W-1:0]   in_op,
  input  logic [CUR_W-1:0]  in_cur,
  input  logic [CUR_W-1:0]  in_mag,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [OP_W-1:0]   out_op,
  output logic [CUR_W-1:0]  out_prev,
  output logic [CUR_W-1:0]  out_val,
  output logic              out_wr
);
  step_t nxt;

  always_comb nxt = step_value(op_type(in_op), in_cur, in_mag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_op    <= '0;
      out_prev  <= '0;
      out_val   <= '0;
      out_wr    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_addr  <= in_addr;
      out_op    <= in_op;
      out_prev  <= in_cur;
      out_val   <= nxt.val;
      out_wr    <= in_valid & nxt.wr;
    end
  end
endmodule

// File: rtl/wq_osc.sv
module wq_osc import wq_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [OP_W-1:0]   host_op,
  input  logic [INC_W-1:0]  host_inc,
  input  logic [CUR_W-1:0]  host_cur,
  output logic [ADDR_W-1:0] rd_slot,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_slot,
  output logic [OP_W-1:0]   out_op,
  output logic [CUR_W-1:0]  out_value,
  output logic [QUAD_W-1:0] out_quad,
  output logic [IDX_W-1:0]  out_index
);
  slot_t             mem [DEPTH];

  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  slot_t             s1_slot;

  logic              s2_valid;
  logic [ADDR_W-1:0] s2_addr;
  logic [OP_W-1:0]   s2_op;
  logic [CUR_W-1:0]  s2_cur;
  logic [CUR_W-1:0]  s2_mag;

  logic              s3_valid;
  logic [ADDR_W-1:0] wb_addr;
  logic [OP_W-1:0]   s3_op;
  logic [CUR_W-1:0]  step_prev;
  logic [CUR_W-1:0]  step_next;
  logic              wb_want;
  logic              host_hit;
  logic              wb_commit;

  wq_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_slot(rd_slot)
  );

  // Stage 1: slot read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_slot  <= '0;
    end else begin
      s1_valid <= 1'b1;
      s1_addr  <= rd_slot;
      s1_slot  <= mem[rd_slot];
    end
  end

  // Stage 2: increment to fixed point
  wq_align_stage #(.ADDR_W(ADDR_W)) u_align (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s1_valid), .in_addr(s1_addr), .in_slot(s1_slot),
    .out_valid(s2_valid), .out_addr(s2_addr), .out_op(s2_op),
    .out_cur(s2_cur), .out_mag(s2_mag)
  );

  // Stage 3: mode rule
  wq_step_stage #(.ADDR_W(ADDR_W)) u_step (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s2_valid), .in_addr(s2_addr), .in_op(s2_op),
    .in_cur(s2_cur), .in_mag(s2_mag),
    .out_valid(s3_valid), .out_addr(wb_addr), .out_op(s3_op),
    .out_prev(step_prev), .out_val(step_next), .out_wr(wb_want)
  );

  assign host_hit  = host_we && (host_addr == wb_addr);
  assign wb_commit = wb_want && !host_hit;

  // Host loads a whole slot; write-back touches only the value field.
  always_ff @(posedge clk) begin
    if (host_we)   mem[host_addr]   <= '{op: host_op, inc: host_inc, cur: host_cur};
    if (wb_commit) mem[wb_addr].cur <= step_next;
  end

  assign out_valid = s3_valid;
  assign out_slot  = wb_addr;
  assign out_op    = s3_op;
  assign out_value = wb_want ? step_next : step_prev;
  assign out_quad  = out_value[CUR_W-1 -: QUAD_W];
  assign out_index = out_value[CUR_W-QUAD_W-1 -: IDX_W];
endmodule

// File: rtl/wq_osc_chk.sv
module wq_osc_chk import wq_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_slot,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_slot,
  input logic [OP_W-1:0]   out_op,
  input logic [CUR_W-1:0]  out_value,
  input logic [CUR_W-1:0]  old_value
);
  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (int'(rd_slot) == (int'($past(rd_slot)) + 1) % DEPTH));

  p_wb_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_slot) == (int'(rd_slot) + DEPTH - 3) % DEPTH));

  p_exp_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_type(out_op) == DT_EXP) |->
      ($signed(out_value) <= $signed(old_value)));

  p_ramp_no_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_type(out_op) == DT_RAMP) |->
      ($signed(out_value) >= $signed(old_value)));

  p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_op[OP_W-1]) |-> (out_value == old_value));
endmodule

bind wq_osc wq_osc_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_slot(rd_slot), .out_valid(out_valid),
  .out_slot(out_slot), .out_op(out_op), .out_value(out_value),
  .old_value(step_prev)
);

// File: tb/wq_osc_bench.sv
module wq_osc_bench;
  import wq_pkg::*;
  localparam int DEPTH  = 64;
  localparam int ADDR_W = 6;
  localparam longint FULL = longint'(1) << 27;
  localparam longint HALF = longint'(1) << 26;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [OP_W-1:0]   host_op = '0;
  logic [INC_W-1:0]  host_inc = '0;
  logic [CUR_W-1:0]  host_cur = '0;
  logic [ADDR_W-1:0] rd_slot;
  logic              out_valid;
  logic [ADDR_W-1:0] out_slot;
  logic [OP_W-1:0]   out_op;
  logic [CUR_W-1:0]  out_value;
  logic [QUAD_W-1:0] out_quad;
  logic [IDX_W-1:0]  out_index;

  wq_osc #(.DEPTH(DEPTH)) u_wq_osc (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_op(host_op), .host_inc(host_inc), .host_cur(host_cur),
    .rd_slot(rd_slot), .out_valid(out_valid), .out_slot(out_slot),
    .out_op(out_op), .out_value(out_value), .out_quad(out_quad),
    .out_index(out_index)
  );

  always #4 clk = ~clk;

  int     n_chk = 0;
  int     n_fail = 0;
  int     m_op  [DEPTH];
  int     m_inc [DEPTH];
  longint m_cur [DEPTH];
  int     last_rd;
  bit     rd_known = 0;
  bit     last_valid;
  int     last_slot;
  longint last_val;
  int     hold_ramp = 0;
  int     hold_exp = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint magnitude(input int op, input int inc);
    longint sig;
    int t;
    t = op / 64;
    sig = inc % 16384;
    if (t <= 1) sig = sig + 16384;
    return (sig * 4096) / (longint'(1) << (inc / 16384));
  endfunction

  function automatic void model_step(input int s, output longint nv, output bit held);
    int t;
    longint c, sc, mag, r;
    t = m_op[s] / 64;
    c = m_cur[s];
    sc = (c >= HALF) ? c - FULL : c;
    mag = magnitude(m_op[s], m_inc[s]);
    held = 1'b0;
    nv = c;
    if (t <= 1) nv = (c + mag) % FULL;
    else if (t == 3 || t == 2) begin
      r = (t == 3) ? sc + mag : sc - mag;
      if (r > HALF - 1 || r < -HALF) held = 1'b1;
      else nv = (r < 0) ? r + FULL : r;
    end
  endfunction

  task automatic put_slot(input int s, input int op, input int inc, input longint cur);
    @(negedge clk);
    host_we = 1'b1; host_addr = ADDR_W'(s); host_op = OP_W'(op);
    host_inc = INC_W'(inc); host_cur = CUR_W'(cur);
    m_op[s] = op; m_inc[s] = inc; m_cur[s] = cur;
  endtask

  // One cycle: sample outputs and compare against the model.
  task automatic visit_check();
    longint e;
    bit held;
    int s, t;
    @(negedge clk);
    if (rd_known)
      chk(int'(rd_slot) == (last_rd + 1) % DEPTH, "R1 slot step", rd_slot, (last_rd + 1) % DEPTH);
    last_rd = rd_slot; rd_known = 1'b1;
    last_valid = out_valid;
    if (out_valid) begin
      s = out_slot;
      t = m_op[s] / 64;
      chk((int'(rd_slot) + DEPTH - s) % DEPTH == 3, "R2 lag", (int'(rd_slot) + DEPTH - s) % DEPTH, 3);
      chk(int'(out_op) == m_op[s], "R4 opcode kept", out_op, m_op[s]);
      model_step(s, e, held);
      if (held && t == 3) hold_ramp++;
      if (held && t == 2) hold_exp++;
      if (t <= 1) begin
        chk(longint'(out_value) == e, "R5 sine step", out_value, e);
        chk(int'(out_quad) == int'(e / (longint'(1) << 25)), "R5 quadrant", out_quad, e / (longint'(1) << 25));
        chk(int'(out_index) == int'((e / 32768) % 1024), "R5 index", out_index, (e / 32768) % 1024);
      end else if (t == 2) chk(longint'(out_value) == e, "R6 exp step", out_value, e);
      else if (t == 3)     chk(longint'(out_value) == e, "R7 ramp step", out_value, e);
      else                 chk(longint'(out_value) == e, "R8 passthrough", out_value, e);
      m_cur[s] = e;
      last_slot = s;
      last_val = out_value;
    end
  endtask

  task automatic t_load_table();
    longint mg;
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      put_slot(i, (i % 8) * 64 + i % 64, (i % 16) * 16384 + (i * 437) % 16384, (longint'(i) * 123457) % FULL);
    mg = magnitude(3 * 64, 4 * 16384 + 16383);
    put_slot(5, 3 * 64, 4 * 16384 + 16383, HALF - 1 - 2 * mg - 5);
    put_slot(6, 2 * 64, 4 * 16384 + 16383, FULL - HALF + 2 * mg + 5);
    put_slot(10, 1 * 64, 0, 0);
    put_slot(11, 3 * 64, 3 * 16384 + 16'h2000, 0);
    put_slot(12, 0, 15 * 16384 + 16383, FULL - 100);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic t_reset_state();
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid low in reset", out_valid, 0);
    chk(rd_slot == '0, "R1 pointer zero in reset", rd_slot, 0);
  endtask

  task automatic t_first_pass();
    int k;
    rst_n = 1'b1;
    last_rd = 0; rd_known = 1'b1;
    k = 0;
    do begin
      visit_check();
      k++;
    end while (!last_valid && k < 10);
    chk(k == 3, "R2 first result after third edge", k, 3);
    chk(last_slot == 0, "R2 first result is slot 0", last_slot, 0);
    for (int n = 0; n < DEPTH; n++) begin
      visit_check();
      if (last_valid && last_slot == 10) begin
        chk(last_val == HALF, "R3 sine shift 0 leading one", last_val, HALF);
        chk(out_quad == 2'd2, "R5 quadrant of half cycle", out_quad, 2);
      end
      if (last_valid && last_slot == 11)
        chk(last_val == 4194304, "R3 ramp shift 3 no leading one", last_val, 4194304);
      if (last_valid && last_slot == 12)
        chk(last_val == 3995, "R5 sine wrap with truncation", last_val, 3995);
    end
  endtask

  task automatic t_run_passes(input int passes);
    for (int n = 0; n < passes * DEPTH; n++) visit_check();
  endtask

  task automatic t_host_collision();
    do visit_check(); while (!(last_valid && last_slot == 20));
    host_we = 1'b1; host_addr = 6'd20; host_op = 9'd64;
    host_inc = 18'(2 * 16384); host_cur = 27'd5;
    m_op[20] = 64; m_inc[20] = 2 * 16384; m_cur[20] = 5;
    visit_check();
    host_we = 1'b0;
    do visit_check(); while (!(last_valid && last_slot == 20));
    chk(last_val == 5 + (longint'(1) << 24), "R9 host wins over write-back", last_val, 5 + (longint'(1) << 24));
  endtask

  task automatic t_limits();
    chk(hold_ramp > 0, "R7 ramp overflow held", hold_ramp, 1);
    chk(hold_exp > 0, "R6 exp underflow held", hold_exp, 1);
    chk(m_cur[5] == HALF - 6, "R7 ramp stopped below limit", m_cur[5], HALF - 6);
    chk(m_cur[6] == FULL - HALF + 5, "R6 exp stopped above limit", m_cur[6], FULL - HALF + 5);
  endtask

  initial begin
    t_load_table();
    t_reset_state();
    t_first_pass();
    t_run_passes(4);
    t_host_collision();
    t_run_passes(2);
    t_limits();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule